// File: doc/BRIEF.md
# PHY Discovery and Link-Up Sequencer

This block brings an Ethernet management port from reset to a known link state without software help. It drives an MDIO frame engine through a simple request/acknowledge handshake, one access at a time. It walks the 32 management addresses in order to find the first PHY that answers. It reads that PHY's two identifier registers, then polls the PHY's basic status register until auto-negotiation has finished and the link is up.

A PHY that is still in reset does not answer. For that case the block repeats the address scan over a bounded number of passes, with a fixed pause before every pass after the first. A bounded status poll keeps a link that never comes up from stalling the sequence. The results are the PHY's address and its 32-bit identifier, a flag that marks them as valid, and done, link-up and error flags. A later start pulse reuses the stored address and only waits for the link again.

Top module: `phy_link_seq`

## Requirements
- R1: After reset, done, linkUp, error and addrValid are 0, phyId is 0 and mdioReq is low until start is pulsed.
- R2: A scan reads register 2 (mdioReg = 2, mdioRead = 1) at PHY addresses 0, 1, ... 31 in ascending order, and each pass starts again at address 0.
- R3: A register-2 reply of 0xFFFF marks the address as empty. The first reply that is not 0xFFFF ends the scan, and no further address is probed.
- R4: After a hit the block reads register 3 at the same address. phyId becomes {register-2 reply, register-3 reply}, phyAddr becomes the hit address and addrValid becomes 1.
- R5: Before each pass after the first, the block pauses for at least DELAY_CYCLES clock cycles. This is measured from the acknowledge of address 31 to the next request.
- R6: When MAX_PASSES passes find nothing, exactly 32*MAX_PASSES probes are made, and the block ends with done=1, error=1, linkUp=0 and addrValid=0.
- R7: After identification the block reads register 1 at the found address until a reply has both bit 5 (auto-negotiation complete) and bit 2 (link up) set. It then ends with done=1, linkUp=1 and error=0.
- R8: When MAX_POLLS status reads all lack either bit, exactly MAX_POLLS reads are made, and the block ends with done=1, error=1 and linkUp=0, while addrValid stays 1.
- R9: A start pulse while addrValid=1 skips the scan. The first access is a register-1 read at the stored address, and no register-2 or register-3 read is made.
- R10: mdioReq, once raised, stays high with mdioPhy and mdioReg unchanged until mdioAck. Only one access is in flight at a time.
- R11: A start pulse while the sequence is running has no effect.
- R12: done, linkUp and error are cleared on the clock edge that accepts a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a sequence when idle or finished |
| mdioReq | output | 1 | Access request to the MDIO frame engine |
| mdioPhy | output | 5 | PHY address of the access |
| mdioReg | output | 5 | Register number of the access |
| mdioRead | output | 1 | 1 = read access |
| mdioAck | input | 1 | One-cycle completion pulse from the frame engine |
| mdioRdData | input | 16 | Read data, valid while mdioAck is high |
| phyAddr | output | 5 | Address of the found PHY |
| phyId | output | 32 | PHY identifier, register 2 in bits 31:16 and register 3 in bits 15:0 |
| addrValid | output | 1 | phyAddr and phyId hold a discovered PHY |
| done | output | 1 | Sequence finished |
| linkUp | output | 1 | Auto-negotiation complete with link up |
| error | output | 1 | No PHY found or link poll timed out |

## Verification
A wrong address or pass counter shows at the MDIO port within one access. The probed address breaks the ascending order, or the probe count at the end of a scan differs from 32 times the pass number plus the hit position. A wrong poll counter or flag state shows only at the end of the sequence, as a wrong count of status reads or a wrong done, linkUp or error combination. A lost identifier-valid state shows on the next restart, as a rescan where a direct status read was expected.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam logic [4:0] REG_STATUS = 5'd1;
  localparam logic [4:0] REG_IDHI   = 5'd2;
  localparam logic [4:0] REG_IDLO   = 5'd3;
  localparam int ANEG_BIT = 5;
  localparam int LINK_BIT = 2;
  localparam logic [15:0] EMPTY_REPLY = 16'hFFFF;

  typedef struct packed {
    logic loadScan;
    logic nextAddr;
    logic nextPass;
    logic tickDelay;
    logic capHi;
    logic capLo;
    logic clearPoll;
    logic bumpPoll;
    logic finLink;
    logic finErr;
    logic clearFlags;
  } seq_strobe_t;
endpackage

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int MAX_PASSES   = 11,
  parameter int DELAY_CYCLES = 2000000,
  parameter int MAX_POLLS    = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t stb,
  input  logic [15:0] rdData,
  output logic [4:0]  addr,
  output logic        addrLast,
  output logic        passLast,
  output logic        delayZero,
  output logic        pollLast,
  output logic [31:0] id,
  output logic        idValid,
  output logic        doneFlag,
  output logic        linkFlag,
  output logic        errFlag
);
  localparam int PASS_W = $clog2(MAX_PASSES + 1);
  localparam int DLY_W  = $clog2(DELAY_CYCLES + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  logic [PASS_W-1:0] passQ;
  logic [DLY_W-1:0]  delayQ;
  logic [POLL_W-1:0] pollQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr     <= '0;
      passQ    <= '0;
      delayQ   <= '0;
      pollQ    <= '0;
      id       <= '0;
      idValid  <= 1'b0;
      doneFlag <= 1'b0;
      linkFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (stb.loadScan) begin
        addr    <= '0;
        passQ   <= '0;
        id      <= '0;
        idValid <= 1'b0;
      end
      if (stb.nextAddr) addr <= addr + 5'd1;
      if (stb.nextPass) begin
        addr   <= '0;
        passQ  <= passQ + 1'b1;
        delayQ <= DLY_W'(DELAY_CYCLES - 1);
      end
      if (stb.tickDelay && delayQ != '0) delayQ <= delayQ - 1'b1;
      if (stb.capHi) id[31:16] <= rdData;
      if (stb.capLo) begin
        id[15:0] <= rdData;
        idValid  <= 1'b1;
      end
      if (stb.clearPoll) pollQ <= '0;
      if (stb.bumpPoll) pollQ <= pollQ + 1'b1;
      if (stb.clearFlags) begin
        doneFlag <= 1'b0;
        linkFlag <= 1'b0;
        errFlag  <= 1'b0;
      end
      if (stb.finLink) begin
        doneFlag <= 1'b1;
        linkFlag <= 1'b1;
      end
      if (stb.finErr) begin
        doneFlag <= 1'b1;
        errFlag  <= 1'b1;
      end
    end
  end

  assign addrLast  = (addr == 5'd31);
  assign passLast  = (passQ == PASS_W'(MAX_PASSES - 1));
  assign delayZero = (delayQ == '0);
  assign pollLast  = (pollQ == POLL_W'(MAX_POLLS - 1));

  // R6
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    passQ <= PASS_W'(MAX_PASSES - 1));

  // R4
  id_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    idValid |-> id[31:16] != EMPTY_REPLY);

  // R7
  link_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(linkFlag && errFlag));

  // R12
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearFlags |=> !doneFlag && !linkFlag && !errFlag);
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        mdioAck,
  input  logic [15:0] mdioRdData,
  input  logic        addrLast,
  input  logic        passLast,
  input  logic        delayZero,
  input  logic        pollLast,
  input  logic        idValid,
  output logic        mdioReq,
  output logic [4:0]  mdioReg,
  output seq_strobe_t stb
);
  typedef enum logic [2:0] {S_IDLE, S_PROBE, S_IDLO, S_PAUSE, S_POLL, S_FIN} seq_state_t;
  seq_state_t state, nextState;

  logic linkReady;
  assign linkReady = mdioRdData[ANEG_BIT] && mdioRdData[LINK_BIT];

  always_comb begin
    nextState = state;
    stb       = '0;
    mdioReq   = 1'b0;
    mdioReg   = REG_STATUS;
    unique case (state)
      S_IDLE, S_FIN: begin
        if (start) begin
          stb.clearFlags = 1'b1;
          if (idValid) begin
            stb.clearPoll = 1'b1;
            nextState     = S_POLL;
          end else begin
            stb.loadScan = 1'b1;
            nextState    = S_PROBE;
          end
        end
      end
      S_PROBE: begin
        mdioReq = 1'b1;
        mdioReg = REG_IDHI;
        if (mdioAck) begin
          if (mdioRdData != EMPTY_REPLY) begin
            stb.capHi = 1'b1;
            nextState = S_IDLO;
          end else if (!addrLast) begin
            stb.nextAddr = 1'b1;
          end else if (passLast) begin
            stb.finErr = 1'b1;
            nextState  = S_FIN;
          end else begin
            stb.nextPass = 1'b1;
            nextState    = S_PAUSE;
          end
        end
      end
      S_IDLO: begin
        mdioReq = 1'b1;
        mdioReg = REG_IDLO;
        if (mdioAck) begin
          stb.capLo     = 1'b1;
          stb.clearPoll = 1'b1;
          nextState     = S_POLL;
        end
      end
      S_PAUSE: begin
        stb.tickDelay = 1'b1;
        if (delayZero) nextState = S_PROBE;
      end
      S_POLL: begin
        mdioReq = 1'b1;
        mdioReg = REG_STATUS;
        if (mdioAck) begin
          if (linkReady) begin
            stb.finLink = 1'b1;
            nextState   = S_FIN;
          end else if (pollLast) begin
            stb.finErr = 1'b1;
            nextState  = S_FIN;
          end else begin
            stb.bumpPoll = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdioReq && !mdioAck) |=> mdioReq && $stable(mdioReg));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE && state != S_FIN) |-> !stb.clearFlags);
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter int MAX_PASSES   = 11,
  parameter int DELAY_CYCLES = 2000000,
  parameter int MAX_POLLS    = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        mdioReq,
  output logic [4:0]  mdioPhy,
  output logic [4:0]  mdioReg,
  output logic        mdioRead,
  input  logic        mdioAck,
  input  logic [15:0] mdioRdData,
  output logic [4:0]  phyAddr,
  output logic [31:0] phyId,
  output logic        addrValid,
  output logic        done,
  output logic        linkUp,
  output logic        error
);
  seq_strobe_t stb;
  logic addrLast, passLast, delayZero, pollLast;

  phy_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .mdioAck(mdioAck), .mdioRdData(mdioRdData),
    .addrLast(addrLast), .passLast(passLast), .delayZero(delayZero),
    .pollLast(pollLast), .idValid(addrValid),
    .mdioReq(mdioReq), .mdioReg(mdioReg), .stb(stb)
  );

  phy_seq_dp #(
    .MAX_PASSES(MAX_PASSES), .DELAY_CYCLES(DELAY_CYCLES), .MAX_POLLS(MAX_POLLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(mdioRdData),
    .addr(phyAddr), .addrLast(addrLast), .passLast(passLast),
    .delayZero(delayZero), .pollLast(pollLast), .id(phyId),
    .idValid(addrValid), .doneFlag(done), .linkFlag(linkUp), .errFlag(error)
  );

  assign mdioPhy  = phyAddr;
  assign mdioRead = 1'b1;

  // R10
  phy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdioReq && !mdioAck) |=> $stable(mdioPhy));

  // R8
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && mdioReq && mdioReg == REG_STATUS) |=> addrValid);
endmodule

// File: tb/tb_phy_link_seq.sv
module tb_phy_link_seq;
  localparam int PASSES = 11;
  localparam int DLY    = 24;
  localparam int POLLS  = 6;
  localparam int NEVER  = 1000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic mdioReq, mdioRead, mdioAck;
  logic [4:0] mdioPhy, mdioReg, phyAddr;
  logic [15:0] mdioRdData;
  logic [31:0] phyId;
  logic addrValid, done, linkUp, error;

  always #2.5 clk = ~clk;

  phy_link_seq #(.MAX_PASSES(PASSES), .DELAY_CYCLES(DLY), .MAX_POLLS(POLLS)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .mdioReq(mdioReq), .mdioPhy(mdioPhy), .mdioReg(mdioReg), .mdioRead(mdioRead),
    .mdioAck(mdioAck), .mdioRdData(mdioRdData),
    .phyAddr(phyAddr), .phyId(phyId), .addrValid(addrValid),
    .done(done), .linkUp(linkUp), .error(error)
  );

  int nChecks = 0, nFails = 0, cyc = 0;
  // responder configuration
  int cfgAddr, cfgAppear, cfgReady;
  logic [15:0] cfgHi, cfgLo;
  // responder log
  int nHi, nLo, nStat, passNo, expAddr, orderBad, flagBad, addrBad, firstReg, minGap, lastAck31;
  int cnt;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    nHi = 0; nLo = 0; nStat = 0; passNo = 0; expAddr = 0; orderBad = 0;
    flagBad = 0; addrBad = 0; firstReg = -1; minGap = NEVER; lastAck31 = -NEVER;
  endtask

  function automatic logic [15:0] statusReply(input int idx);
    logic [15:0] r = 16'($urandom);
    if (idx > cfgReady) return r | 16'h0024;
    case (idx % 3)
      0: return r & ~16'h0024;
      1: return (r & ~16'h0024) | 16'h0020;
      default: return (r & ~16'h0024) | 16'h0004;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      mdioAck = 1'b0; mdioRdData = 16'h0; cnt = -1;
    end else if (mdioAck) begin
      mdioAck = 1'b0;
    end else if (mdioReq) begin
      if (cnt < 0) begin
        cnt = int'($urandom_range(0, 3));
        if (firstReg < 0) firstReg = mdioReg;
        if (mdioReg == 5'd2 && mdioPhy == 5'd0 && passNo >= 1 && (cyc - lastAck31) < minGap)
          minGap = cyc - lastAck31;
      end
      if (cnt == 0) begin
        cnt = -1;
        mdioAck = 1'b1;
        if (!mdioRead) flagBad++;
        if (mdioReg == 5'd2) begin
          if (mdioPhy == 5'd0) passNo++;
          if (int'(mdioPhy) != expAddr) orderBad++;
          expAddr = (expAddr + 1) % 32;
          nHi++;
          mdioRdData = (int'(mdioPhy) == cfgAddr && passNo >= cfgAppear) ? cfgHi : 16'hFFFF;
          if (mdioPhy == 5'd31) lastAck31 = cyc;
        end else if (mdioReg == 5'd3) begin
          nLo++;
          if (int'(mdioPhy) != cfgAddr) addrBad++;
          mdioRdData = cfgLo;
        end else begin
          nStat++;
          if (int'(mdioPhy) != cfgAddr) addrBad++;
          mdioRdData = statusReply(nStat);
        end
      end else cnt--;
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    check(done, {tag, " watchdog"}, done, 1);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runFound(input int a, input int p, input logic [15:0] hi,
                          input logic [15:0] lo, input int rdy);
    cfgAddr = a; cfgAppear = p; cfgHi = hi; cfgLo = lo; cfgReady = rdy;
    doReset();
    clearLog();
    pulseStart();
    waitDone("R7");
    check(nHi == 32 * (p - 1) + a + 1, "R3 probe count", nHi, 32 * (p - 1) + a + 1);
    check(orderBad == 0 && flagBad == 0, "R2 ascending read probes", orderBad + flagBad, 0);
    check(nLo == 1 && addrBad == 0, "R4 id2 read at hit address", nLo + addrBad, 1);
    check(phyId == {hi, lo}, "R4 phyId", phyId, {hi, lo});
    check(phyAddr == 5'(a) && addrValid, "R4 phyAddr", {addrValid, phyAddr}, {1'b1, 5'(a)});
    if (p > 1) check(minGap >= DLY, "R5 pass gap", minGap, DLY);
    if (rdy < POLLS) begin
      check(linkUp && !error, "R7 link flags", {linkUp, error}, 2'b10);
      check(nStat == rdy + 1, "R7 poll count", nStat, rdy + 1);
    end else begin
      check(!linkUp && error && addrValid, "R8 timeout flags", {linkUp, error, addrValid}, 3'b011);
      check(nStat == POLLS, "R8 poll count", nStat, POLLS);
    end
  endtask

  initial begin
    int wd = 0;
    clearLog();
    cfgAddr = -1; cfgAppear = 1; cfgHi = 16'h0; cfgLo = 16'h0; cfgReady = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !linkUp && !error && !addrValid && phyId == 0 && !mdioReq,
          "R1 reset outputs", {done, linkUp, error, addrValid, mdioReq}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!mdioReq && !done, "R1 idle without start", {mdioReq, done}, 0);

    // directed: hit at address 5 on the first pass
    runFound(5, 1, 16'h0022, 16'h1619, 2);

    // R9: restart reuses the stored address
    clearLog();
    pulseStart();
    check(!done, "R12 flags cleared on start", done, 0);
    waitDone("R9");
    check(nHi == 0 && nLo == 0, "R9 no rescan", nHi + nLo, 0);
    check(firstReg == 1 && addrBad == 0, "R9 status read first", firstReg, 1);
    check(linkUp && phyAddr == 5'd5, "R9 link after restart", {linkUp, phyAddr}, {1'b1, 5'd5});

    // R11: start while scanning ignored; PHY at last address, third pass
    cfgAddr = 31; cfgAppear = 3; cfgHi = 16'h2000; cfgLo = 16'h5C90; cfgReady = 0;
    doReset();
    clearLog();
    pulseStart();
    repeat (40) @(negedge clk);
    pulseStart();
    waitDone("R11");
    check(nHi == 96 && orderBad == 0, "R11 busy start ignored", nHi, 96);
    check(minGap >= DLY, "R5 gap before later passes", minGap, DLY);
    check(phyId == 32'h20005C90 && linkUp, "R4 id at address 31", phyId, 32'h20005C90);

    // R6: no PHY anywhere
    cfgAddr = -1; cfgAppear = 1;
    doReset();
    clearLog();
    pulseStart();
    waitDone("R6");
    check(nHi == 32 * PASSES && orderBad == 0, "R6 probe total", nHi, 32 * PASSES);
    check(error && !linkUp && !addrValid && nStat == 0, "R6 failure flags",
          {error, linkUp, addrValid}, 3'b100);

    // R8: link never comes up
    runFound(0, 1, 16'h0181, 16'h4400, NEVER);

    // random mix
    for (int i = 0; i < 6; i++) begin
      int a = int'($urandom_range(0, 31));
      int p = int'($urandom_range(1, 3));
      logic [15:0] hi = 16'($urandom_range(0, 16'hFFFE));
      logic [15:0] lo = 16'($urandom);
      int r = int'($urandom_range(0, POLLS));
      runFound(a, p, hi, lo, r);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(5 * 190000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule